// File: doc/BRIEF.md
# Shared-Page Vector Clock Coherence Tracker

This block records, for each shared page held by one node of an N-node system, two vector clocks. The arrival vector notes how far the writes from each node have landed in the local copy. The requirement vector notes how far they must have landed before the copy may be read or written. A page is usable when its requirement vector is covered entry by entry by its arrival vector. The block also keeps a node-wide requirement vector. This vector is the elementwise maximum of everything merged into any page, and it is what the node offers when it asks for a lock.

Four kinds of event drive it. A link flush raises one node's entry of one page's arrival vector. A lock grant merges a received vector into one page's requirement vector. A local release advances the node's own logical clock and stamps the new value into the page set written during the interval. An access probe asks whether a page may be touched. A page that a lock grant leaves behind is flagged as unmapped and keeps its contents. A probe against a stale page raises a stall that drops only when the missing flushes have arrived.

Top module: `vts_tracker`

## Requirements
- R1: After a synchronous active-high reset, all vector entries, the local clock and the node-wide vector are zero, every page reads current, no page is unmapped, and neither stall nor grant is raised.
- R2: A flush event for page p, node n and value v sets arrival entry (p,n) to the larger of its old value and v (unsigned). A smaller v leaves the entry unchanged.
- R3: A lock grant for page p carrying vector V sets each requirement entry of p to the larger of the old entry and the matching field of V. Node i is carried in bits [i*TSW +: TSW].
- R4: page_current[p] is 1 exactly when every requirement entry of p is less than or equal to the matching arrival entry, under unsigned comparison.
- R5: page_unmapped[p] becomes 1 when a lock grant leaves page p not current. It returns to 0 only on a granted access to p. When both happen in the same cycle, setting wins.
- R6: A probe accepted at a clock edge is answered from the next cycle. If the page is current, access_grant is high for exactly one cycle. Otherwise access_stall is held until the page becomes current, and the one-cycle grant follows.
- R7: When a flush, release or lock grant for a page falls in the same cycle as a probe of that page, the probe is judged on the updated vectors.
- R8: global_lock is the elementwise maximum of all vectors received in lock grants since reset.
- R9: Each release raises local_clock by one, saturating at 2^TSW-1. The new value is merged into the LOCAL_NODE arrival entry of every page whose bit is set in rel_pages.
- R10: A probe that arrives while an earlier probe is still outstanding is ignored. A probe whose page index is PAGES or greater is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_valid | input | 1 | Flush event strobe |
| flush_page | input | PW | Page of the flush event |
| flush_node | input | NW | Node entry raised by the flush |
| flush_clock | input | TSW | Clock value carried by the flush |
| acq_valid | input | 1 | Lock grant strobe |
| acq_page | input | PW | Page whose requirement vector is merged |
| acq_vec | input | NODES*TSW | Received vector, node i at [i*TSW +: TSW] |
| rel_valid | input | 1 | Local release strobe |
| rel_pages | input | PAGES | Pages written during the closing interval |
| qry_valid | input | 1 | Access probe strobe |
| qry_page | input | PW | Page being probed |
| page_current | output | PAGES | Per-page coverage flag |
| page_unmapped | output | PAGES | Per-page unmapped flag |
| access_stall | output | 1 | Outstanding probe waits on a stale page |
| access_grant | output | 1 | One-cycle grant of the outstanding probe |
| global_lock | output | NODES*TSW | Node-wide requirement vector |
| local_clock | output | TSW | Local logical clock |

## Verification
The bench builds the block with four nodes, four pages and four-bit entries. With these values the local clock saturates after fifteen releases, so the saturation corner is reached inside a short directed run. Small random clock values also make equal, lower and higher entry comparisons frequent. Four nodes and four pages are enough to mix flushes to one page with grants to another in the same cycle. They also allow a probe to be refused while another waits, and an unmapped page to be re-stamped by a grant in the very cycle its access is granted.

// File: rtl/vts_pkg.sv
package vts_pkg;

    // Index width for a count of items, never narrower than one bit.
    function automatic int idx_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_WAIT = 1'b1
    } acc_state_e;

endpackage

// File: rtl/vts_vec_max.sv
module vts_vec_max #(
    parameter int NODES = 4,
    parameter int TSW   = 4
) (
    input  logic [NODES*TSW-1:0] a,
    input  logic [NODES*TSW-1:0] b,
    output logic [NODES*TSW-1:0] y
);
    for (genvar i = 0; i < NODES; i++) begin : g_ent
        assign y[i*TSW +: TSW] = (a[i*TSW +: TSW] > b[i*TSW +: TSW]) ?
                                 a[i*TSW +: TSW] : b[i*TSW +: TSW];
    end
endmodule

// File: rtl/vts_dominates.sv
module vts_dominates #(
    parameter int NODES = 4,
    parameter int TSW   = 4
) (
    input  logic [NODES*TSW-1:0] need,
    input  logic [NODES*TSW-1:0] have,
    output logic                 covered
);
    logic [NODES-1:0] le;
    for (genvar i = 0; i < NODES; i++) begin : g_ent
        assign le[i] = need[i*TSW +: TSW] <= have[i*TSW +: TSW];
    end
    assign covered = &le;
endmodule

// File: rtl/vts_page_slot.sv
module vts_page_slot
    import vts_pkg::*;
#(
    parameter int NODES      = 4,
    parameter int TSW        = 4,
    parameter int LOCAL_NODE = 0,
    parameter int NW         = idx_w(NODES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush_hit,
    input  logic [NW-1:0]        flush_node,
    input  logic [TSW-1:0]       flush_clock,
    input  logic                 rel_hit,
    input  logic [TSW-1:0]       rel_clock,
    input  logic                 acq_hit,
    input  logic [NODES*TSW-1:0] acq_vec,
    input  logic                 grant_hit,
    output logic                 current,
    output logic                 unmapped
);
    localparam int VW = NODES * TSW;

    logic [VW-1:0] arr_q, arr_n;
    logic [VW-1:0] req_q, req_n, req_merged;
    logic          unm_q, cur_after;

    always_comb begin
        arr_n = arr_q;
        for (int i = 0; i < NODES; i++) begin
            if (flush_hit && flush_node == NW'(i) &&
                flush_clock > arr_q[i*TSW +: TSW])
                arr_n[i*TSW +: TSW] = flush_clock;
        end
        if (rel_hit && rel_clock > arr_n[LOCAL_NODE*TSW +: TSW])
            arr_n[LOCAL_NODE*TSW +: TSW] = rel_clock;
    end

    vts_vec_max #(.NODES(NODES), .TSW(TSW)) u_merge (
        .a(req_q), .b(acq_vec), .y(req_merged)
    );
    assign req_n = acq_hit ? req_merged : req_q;

    vts_dominates #(.NODES(NODES), .TSW(TSW)) u_cur_now (
        .need(req_q), .have(arr_q), .covered(current)
    );
    vts_dominates #(.NODES(NODES), .TSW(TSW)) u_cur_next (
        .need(req_n), .have(arr_n), .covered(cur_after)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_q <= '0;
            req_q <= '0;
            unm_q <= 1'b0;
        end else begin
            arr_q <= arr_n;
            req_q <= req_n;
            if (acq_hit && !cur_after)
                unm_q <= 1'b1;
            else if (grant_hit)
                unm_q <= 1'b0;
        end
    end

    assign unmapped = unm_q;
endmodule

// File: rtl/vts_tracker.sv
module vts_tracker
    import vts_pkg::*;
#(
    parameter int NODES      = 4,
    parameter int PAGES      = 4,
    parameter int TSW        = 4,
    parameter int LOCAL_NODE = 0,
    parameter int NW         = idx_w(NODES),
    parameter int PW         = idx_w(PAGES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush_valid,
    input  logic [PW-1:0]        flush_page,
    input  logic [NW-1:0]        flush_node,
    input  logic [TSW-1:0]       flush_clock,
    input  logic                 acq_valid,
    input  logic [PW-1:0]        acq_page,
    input  logic [NODES*TSW-1:0] acq_vec,
    input  logic                 rel_valid,
    input  logic [PAGES-1:0]     rel_pages,
    input  logic                 qry_valid,
    input  logic [PW-1:0]        qry_page,
    output logic [PAGES-1:0]     page_current,
    output logic [PAGES-1:0]     page_unmapped,
    output logic                 access_stall,
    output logic                 access_grant,
    output logic [NODES*TSW-1:0] global_lock,
    output logic [TSW-1:0]       local_clock
);
    localparam logic [TSW-1:0] CLK_TOP = '1;

    logic [TSW-1:0]       lclk_q, lclk_n;
    logic [NODES*TSW-1:0] glob_q, glob_merged;
    acc_state_e           acc_q;
    logic [PW-1:0]        acc_page_q;
    logic                 probe_ok, pend_cur;

    // Local logical clock, saturating.
    assign lclk_n = (lclk_q == CLK_TOP) ? lclk_q : lclk_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)            lclk_q <= '0;
        else if (rel_valid) lclk_q <= lclk_n;
    end

    // Node-wide requirement vector.
    vts_vec_max #(.NODES(NODES), .TSW(TSW)) u_glob (
        .a(glob_q), .b(acq_vec), .y(glob_merged)
    );

    always_ff @(posedge clk) begin
        if (rst)            glob_q <= '0;
        else if (acq_valid) glob_q <= glob_merged;
    end

    // Per-page state.
    for (genvar p = 0; p < PAGES; p++) begin : g_page
        vts_page_slot #(
            .NODES(NODES), .TSW(TSW), .LOCAL_NODE(LOCAL_NODE), .NW(NW)
        ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .flush_hit  (flush_valid && flush_page == PW'(p)),
            .flush_node (flush_node),
            .flush_clock(flush_clock),
            .rel_hit    (rel_valid && rel_pages[p]),
            .rel_clock  (lclk_n),
            .acq_hit    (acq_valid && acq_page == PW'(p)),
            .acq_vec    (acq_vec),
            .grant_hit  (access_grant && acc_page_q == PW'(p)),
            .current    (page_current[p]),
            .unmapped   (page_unmapped[p])
        );
    end

    // Access probe: captured at an edge, judged on the registered vectors.
    assign probe_ok = qry_valid && (32'(qry_page) < PAGES);
    assign pend_cur = page_current[acc_page_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= ACC_IDLE;
            acc_page_q <= '0;
        end else begin
            case (acc_q)
                ACC_IDLE: if (probe_ok) begin
                    acc_q      <= ACC_WAIT;
                    acc_page_q <= qry_page;
                end
                ACC_WAIT: if (pend_cur) acc_q <= ACC_IDLE;
                default:  acc_q <= ACC_IDLE;
            endcase
        end
    end

    assign access_grant = (acc_q == ACC_WAIT) &&  pend_cur;
    assign access_stall = (acc_q == ACC_WAIT) && !pend_cur;
    assign global_lock  = glob_q;
    assign local_clock  = lclk_q;
endmodule

// File: rtl/vts_checker.sv
module vts_checker #(
    parameter int NODES = 4,
    parameter int PAGES = 4,
    parameter int TSW   = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 acq_valid,
    input logic                 rel_valid,
    input logic [PAGES-1:0]     page_unmapped,
    input logic                 access_stall,
    input logic                 access_grant,
    input logic [NODES*TSW-1:0] global_lock,
    input logic [TSW-1:0]       local_clock
);
    localparam logic [TSW-1:0] CLK_TOP = '1;

    p_grant_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(access_grant && access_stall));

    p_stall_resolves_r6: assert property (@(posedge clk) disable iff (rst)
        access_stall |=> (access_stall || access_grant));

    p_grant_single_r6: assert property (@(posedge clk) disable iff (rst)
        access_grant |=> (!access_grant && !access_stall));

    p_unmap_clear_r5: assert property (@(posedge clk) disable iff (rst)
        !access_grant |=> (($past(page_unmapped) & ~page_unmapped) == '0));

    p_clock_step_r9: assert property (@(posedge clk) disable iff (rst)
        (rel_valid && local_clock != CLK_TOP) |=>
        (local_clock == $past(local_clock) + 1'b1));

    p_clock_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!rel_valid || local_clock == CLK_TOP) |=> $stable(local_clock));

    p_glob_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !acq_valid |=> $stable(global_lock));

    for (genvar i = 0; i < NODES; i++) begin : g_mono
        p_glob_mono_r8: assert property (@(posedge clk) disable iff (rst)
            acq_valid |=> (global_lock[i*TSW +: TSW] >=
                           $past(global_lock[i*TSW +: TSW])));
    end
endmodule

bind vts_tracker vts_checker #(.NODES(NODES), .PAGES(PAGES), .TSW(TSW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .acq_valid    (acq_valid),
    .rel_valid    (rel_valid),
    .page_unmapped(page_unmapped),
    .access_stall (access_stall),
    .access_grant (access_grant),
    .global_lock  (global_lock),
    .local_clock  (local_clock)
);

// File: tb/vts_tracker_test.sv
module vts_tracker_test;
    localparam int NODES = 4;
    localparam int PAGES = 4;
    localparam int TSW   = 4;
    localparam int LOCN  = 0;
    localparam int NW    = 2;
    localparam int PW    = 2;
    localparam int TOP   = 15;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 flush_valid, acq_valid, rel_valid, qry_valid;
    logic [PW-1:0]        flush_page, acq_page, qry_page;
    logic [NW-1:0]        flush_node;
    logic [TSW-1:0]       flush_clock;
    logic [NODES*TSW-1:0] acq_vec;
    logic [PAGES-1:0]     rel_pages;
    logic [PAGES-1:0]     page_current, page_unmapped;
    logic                 access_stall, access_grant;
    logic [NODES*TSW-1:0] global_lock;
    logic [TSW-1:0]       local_clock;

    vts_tracker #(.NODES(NODES), .PAGES(PAGES), .TSW(TSW), .LOCAL_NODE(LOCN)) uut (
        .clk(clk), .rst(rst),
        .flush_valid(flush_valid), .flush_page(flush_page),
        .flush_node(flush_node), .flush_clock(flush_clock),
        .acq_valid(acq_valid), .acq_page(acq_page), .acq_vec(acq_vec),
        .rel_valid(rel_valid), .rel_pages(rel_pages),
        .qry_valid(qry_valid), .qry_page(qry_page),
        .page_current(page_current), .page_unmapped(page_unmapped),
        .access_stall(access_stall), .access_grant(access_grant),
        .global_lock(global_lock), .local_clock(local_clock)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // Behavioural reference state.
    int mf [PAGES][NODES];
    int ml [PAGES][NODES];
    bit mu [PAGES];
    int mg [NODES];
    bit mpend;
    int mpage;
    int mclk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit mcur(input int p);
        for (int n = 0; n < NODES; n++)
            if (ml[p][n] > mf[p][n]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int vfield(input logic [NODES*TSW-1:0] v, input int n);
        return int'(v[n*TSW +: TSW]);
    endfunction

    task automatic model_step();
        bit g;
        int nc;
        if (rst) begin
            for (int p = 0; p < PAGES; p++) begin
                mu[p] = 0;
                for (int n = 0; n < NODES; n++) begin
                    mf[p][n] = 0;
                    ml[p][n] = 0;
                end
            end
            for (int n = 0; n < NODES; n++) mg[n] = 0;
            mpend = 0; mpage = 0; mclk = 0;
            return;
        end
        g  = mpend && mcur(mpage);
        nc = (mclk == TOP) ? mclk : mclk + 1;
        for (int p = 0; p < PAGES; p++) begin
            if (flush_valid && int'(flush_page) == p &&
                int'(flush_clock) > mf[p][int'(flush_node)])
                mf[p][int'(flush_node)] = int'(flush_clock);
            if (rel_valid && rel_pages[p] && nc > mf[p][LOCN])
                mf[p][LOCN] = nc;
            if (acq_valid && int'(acq_page) == p)
                for (int n = 0; n < NODES; n++)
                    if (vfield(acq_vec, n) > ml[p][n]) ml[p][n] = vfield(acq_vec, n);
            if (acq_valid && int'(acq_page) == p && !mcur(p)) mu[p] = 1;
            else if (g && mpage == p) mu[p] = 0;
        end
        if (!mpend) begin
            if (qry_valid && int'(qry_page) < PAGES) begin
                mpend = 1;
                mpage = int'(qry_page);
            end
        end else if (g) mpend = 0;
        if (rel_valid) mclk = nc;
        if (acq_valid)
            for (int n = 0; n < NODES; n++)
                if (vfield(acq_vec, n) > mg[n]) mg[n] = vfield(acq_vec, n);
    endtask

    task automatic compare_all(input bit in_reset);
        for (int p = 0; p < PAGES; p++) begin
            chk(in_reset ? "R1 current" : "R4 current", int'(page_current[p]), int'(mcur(p)));
            chk(in_reset ? "R1 unmapped" : "R5 unmapped", int'(page_unmapped[p]), int'(mu[p]));
        end
        chk(in_reset ? "R1 stall" : "R6 stall", int'(access_stall), int'(mpend && !mcur(mpage)));
        chk(in_reset ? "R1 grant" : "R6 grant", int'(access_grant), int'(mpend && mcur(mpage)));
        for (int n = 0; n < NODES; n++)
            chk(in_reset ? "R1 global" : "R8 global", vfield(global_lock, n), mg[n]);
        chk(in_reset ? "R1 clock" : "R9 clock", int'(local_clock), mclk);
    endtask

    task automatic tick();
        bit was_rst;
        @(posedge clk);
        was_rst = rst;
        model_step();
        @(negedge clk);
        compare_all(was_rst);
    endtask

    task automatic idle();
        flush_valid = 0; acq_valid = 0; rel_valid = 0; qry_valid = 0;
        flush_page = '0; flush_node = '0; flush_clock = '0;
        acq_page = '0; acq_vec = '0; rel_pages = '0; qry_page = '0;
    endtask

    function automatic logic [NODES*TSW-1:0] one_entry(input int n, input int v);
        logic [NODES*TSW-1:0] r = '0;
        r[n*TSW +: TSW] = TSW'(v);
        return r;
    endfunction

    task automatic set_flush(input int p, input int n, input int v);
        flush_valid = 1; flush_page = PW'(p); flush_node = NW'(n); flush_clock = TSW'(v);
    endtask
    task automatic set_acq(input int p, input logic [NODES*TSW-1:0] v);
        acq_valid = 1; acq_page = PW'(p); acq_vec = v;
    endtask
    task automatic set_qry(input int p);
        qry_valid = 1; qry_page = PW'(p);
    endtask
    task automatic set_rel(input logic [PAGES-1:0] m);
        rel_valid = 1; rel_pages = m;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL R6 watchdog: got 0 expected 1 (run did not end)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        @(negedge clk);
        repeat (3) tick();
        rst = 0;
        tick();
        chk("R1 all current", int'(page_current), 15);

        // R3/R5: grant leaves page 1 behind on node 1
        set_acq(1, one_entry(1, 3)); tick(); idle();
        chk("R3 page1 stale", int'(page_current[1]), 0);
        chk("R5 page1 unmapped", int'(page_unmapped[1]), 1);
        // R6: probe stalls until flush catches up
        set_qry(1); tick(); idle();
        chk("R6 stall raised", int'(access_stall), 1);
        set_flush(1, 1, 2); tick(); idle();
        chk("R2 partial flush keeps stall", int'(access_stall), 1);
        set_flush(1, 1, 3); tick(); idle();
        chk("R6 grant after catch-up", int'(access_grant), 1);
        tick();
        chk("R5 unmapped cleared by grant", int'(page_unmapped[1]), 0);

        // R2: a lower flush does not lower an entry
        set_flush(2, 2, 5); tick(); idle();
        set_flush(2, 2, 3); tick(); idle();
        set_acq(2, one_entry(2, 5)); tick(); idle();
        chk("R2 entry not lowered", int'(page_current[2]), 1);
        chk("R2 no unmap", int'(page_unmapped[2]), 0);

        // R7: flush and probe in the same cycle
        set_acq(3, one_entry(3, 4)); tick(); idle();
        set_qry(3); set_flush(3, 3, 4); tick(); idle();
        chk("R7 update first", int'(access_grant), 1);
        chk("R7 no stall", int'(access_stall), 0);
        tick();

        // R10: second probe while one is outstanding is ignored
        set_acq(0, one_entry(1, 7)); tick(); idle();
        set_qry(0); tick(); idle();
        set_qry(2); tick(); idle();
        chk("R10 still stalled on page0", int'(access_stall), 1);
        set_flush(0, 1, 7); tick(); idle();
        chk("R10 grant for page0", int'(access_grant), 1);
        tick();
        chk("R10 probe dropped", int'(access_stall | access_grant), 0);

        // R9: release stamps local entry; saturation
        set_rel(4'b0001); tick(); idle();
        chk("R9 clock one", int'(local_clock), 1);
        set_acq(0, one_entry(LOCN, 2)); tick(); idle();
        chk("R9 page0 stale on local", int'(page_current[0]), 0);
        set_rel(4'b0001); tick(); idle();
        chk("R9 release refreshes page0", int'(page_current[0]), 1);
        for (int k = 0; k < 20; k++) begin
            set_rel(4'b0101); tick(); idle();
        end
        chk("R9 saturated", int'(local_clock), TOP);
        set_acq(2, one_entry(LOCN, TOP)); tick(); idle();
        chk("R9 page2 stamped at top", int'(page_current[2]), 1);
        chk("R8 global local entry", vfield(global_lock, LOCN), TOP);

        // Mixed random traffic, compared every cycle against the model
        for (int k = 0; k < 3000; k++) begin
            idle();
            if ($urandom_range(0, 3) == 0) set_flush($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 15));
            if ($urandom_range(0, 7) == 0) set_acq($urandom_range(0, 3), one_entry($urandom_range(1, 3), $urandom_range(0, 15)));
            if ($urandom_range(0, 15) == 0) set_rel(PAGES'($urandom_range(0, 15)));
            if ($urandom_range(0, 2) == 0) set_qry($urandom_range(0, 3));
            tick();
        end
        idle();
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule